// File: doc/BRIEF.md
# Hysteretic Buck Gate-Drive Sequencer

This block turns a synchronized current-feedback comparator bit into the two gate enables of a half-bridge buck stage, so that the average load current is held by hysteresis. While the feedback reads below the reference, the high-side switch conducts. Once it reads above, the high side is released and the low side takes over. Every threshold crossing is followed by a fixed turn-off delay and a longer turn-on delay. The gap between them is the dead time that keeps the two switches apart.

Several supervisory behaviours sit around the regulation loop. A deglitch stage accepts a new feedback level only after it has persisted. A watchdog cuts the high side after a long continuous on-time and gives the low side a short pulse, so the floating bootstrap supply can recharge. An active-high disable parks the bridge with the low side on. Supply lockout with hysteresis turns both switches off. On leaving lockout, a precharge phase holds the low side on before switching begins. Every interval is entered in nanoseconds and converted to clock cycles at elaboration, using a clock-frequency parameter. The conversion rounds up, and a result below one becomes one.

Top module: `hbk_gate_seq`

## Requirements
- R1: `hs_gate_o` and `ls_gate_o` are never high in the same cycle. A rising edge of `hs_gate_o` is always preceded by at least one cycle with `ls_gate_o` low.
- R2: When `fb_above_i` goes from 0 to 1 and the new level is accepted, `hs_gate_o` falls exactly FILT+OFF clock edges after the input change and `ls_gate_o` rises exactly FILT+ON edges after it. At the default settings FILT=4, OFF=18 and ON=32.
- R3: When `fb_above_i` goes from 1 to 0 and the new level is accepted, `ls_gate_o` falls FILT+OFF edges after the change and `hs_gate_o` rises FILT+ON edges after it.
- R4: A feedback level that lasts fewer than FILT consecutive cycles has no effect on either output.
- R5: If the accepted feedback reverses while a transition is still pending, that transition is cancelled. A side that is already off stays off. The newly wanted side turns on ON edges after the reversal is accepted.
- R6: After `hs_gate_o` has been high for WD consecutive cycles (2000 by default), it is forced low and `ls_gate_o` is forced high for REF cycles (100 by default). `ls_gate_o` then drops, and `hs_gate_o` returns ON-OFF cycles later.
- R7: While `disable_i` is 1, the outputs become `hs_gate_o`=0 and `ls_gate_o`=1 one cycle after it is sampled, and feedback changes are ignored. On release, the same timing as a fresh crossing is counted from the first edge that samples `disable_i` low.
- R8: The block starts in lockout after reset. In lockout both outputs are 0. Lockout is entered at the first clock edge that samples `vdd_below_off_i`=1 while the block is not locked. The outputs follow two edges after that input changes.
- R9: Lockout is left only when `vdd_above_on_i`=1. With both supply flags at 0, the current lockout state is kept, whether that is locked or unlocked.
- R10: Two edges after `vdd_above_on_i` is raised during lockout, `ls_gate_o`=1 and `hs_gate_o`=0. This state is held for PRE cycles (1000 by default). Regulation then starts, with crossing timing counted from the end of precharge.
- R11: Every interval is ceil(ns × CLK_MHZ / 1000) cycles, with a minimum of 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fb_above_i | input | 1 | Synchronized feedback comparator bit; 1 means above the reference |
| disable_i | input | 1 | Active-high disable |
| vdd_above_on_i | input | 1 | Supply is above the rising lockout threshold |
| vdd_below_off_i | input | 1 | Supply is below the falling lockout threshold |
| hs_gate_o | output | 1 | High-side gate enable |
| ls_gate_o | output | 1 | Low-side gate enable |

## Verification
The feedback is driven in clean rising and falling steps, each checked one edge before and at the exact edge of every transition. These checks separate a correct delay from one that is off by one and from a swapped delay pair. A pulse one cycle shorter than the filter window confirms that the filter length is exact. A reversal placed between the turn-off and the expected turn-on shows whether a pending turn-on is cancelled or wrongly completed. A feedback bit held long enough to trip the watchdog, a disable period with the feedback toggling, and supply flags stepped through both thresholds and the band between them show the differing safe states and the lockout hysteresis.

// File: rtl/hbk_pkg.sv
package hbk_pkg;

  typedef enum logic [2:0] {
    PH_LOCK,
    PH_PRE,
    PH_RUN,
    PH_REFRESH,
    PH_DIS
  } phase_t;

  // Interval in ns -> clock cycles, rounded up, never below one
  function automatic int ns_to_cyc(input int clk_mhz, input int ns);
    int c;
    c = (ns * clk_mhz + 999) / 1000;
    if (c < 1) c = 1;
    return c;
  endfunction

  // Bits needed to hold values 0..maxv
  function automatic int cnt_width(input int maxv);
    return (maxv < 2) ? 1 : $clog2(maxv + 1);
  endfunction

endpackage

// File: rtl/hbk_deglitch.sv
module hbk_deglitch #(
  parameter int HOLD = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic raw_i,
  output logic lvl_o,
  output logic take_o
);
  localparam int CW = hbk_pkg::cnt_width(HOLD);
  localparam logic [CW-1:0] LAST = CW'(HOLD - 1);

  logic [CW-1:0] run_q;
  logic          lvl_q;
  logic          differs;

  assign differs = (raw_i != lvl_q);
  assign take_o  = differs && (run_q == LAST);
  assign lvl_o   = lvl_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      lvl_q <= 1'b1;
      run_q <= '0;
    end else if (take_o) begin
      lvl_q <= raw_i;
      run_q <= '0;
    end else if (differs) begin
      run_q <= run_q + 1'b1;
    end else begin
      run_q <= '0;
    end
  end

  // R4
  flt_accept_chk: assert property (@(posedge clk) disable iff (rst)
    !$stable(lvl_q) |-> (lvl_q == $past(raw_i)));

endmodule

// File: rtl/hbk_uvlo.sv
module hbk_uvlo (
  input  logic clk,
  input  logic rst,
  input  logic above_on_i,
  input  logic below_off_i,
  output logic lock_o
);
  logic lock_q;

  always_ff @(posedge clk) begin
    if (rst)                          lock_q <= 1'b1;
    else if (lock_q && above_on_i)    lock_q <= 1'b0;
    else if (!lock_q && below_off_i)  lock_q <= 1'b1;
  end

  assign lock_o = lock_q;

  // R9
  hyst_enter_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(lock_q) |-> $past(below_off_i));

  // R9
  hyst_leave_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(lock_q) |-> $past(above_on_i));

endmodule

// File: rtl/hbk_phase_ctl.sv
module hbk_phase_ctl #(
  parameter int OFF_C = 18,
  parameter int ON_C  = 32,
  parameter int WD_C  = 2000,
  parameter int REF_C = 100,
  parameter int PRE_C = 1000
) (
  input  logic clk,
  input  logic rst,
  input  logic lock_i,
  input  logic dis_i,
  input  logic lvl_i,
  input  logic take_i,
  output logic hs_o,
  output logic ls_o
);
  import hbk_pkg::*;

  localparam int DW = cnt_width(ON_C);
  localparam int WW = cnt_width(WD_C);
  localparam int TW = cnt_width((PRE_C > REF_C) ? PRE_C : REF_C);
  localparam logic [DW-1:0] OFF_LAST = DW'(OFF_C - 1);
  localparam logic [DW-1:0] ON_LAST  = DW'(ON_C - 1);
  localparam logic [DW-1:0] OFF_SET  = DW'(OFF_C);
  localparam logic [WW-1:0] WD_LAST  = WW'(WD_C - 1);
  localparam logic [TW-1:0] PRE_LAST = TW'(PRE_C - 1);
  localparam logic [TW-1:0] REF_LAST = TW'(REF_C - 1);

  phase_t        ph_q;
  logic          hs_q, ls_q;
  logic [DW-1:0] dly_q;
  logic [WW-1:0] wd_q;
  logic [TW-1:0] tmr_q;

  logic want_hs, off_due, on_due, hs_nx, ls_nx, wd_fire, hs_run;

  assign want_hs = !lvl_i;
  assign off_due = (dly_q >= OFF_LAST);
  assign on_due  = (dly_q == ON_LAST);
  assign hs_run  = (ph_q == PH_RUN) && hs_q;
  assign wd_fire = hs_run && (wd_q == WD_LAST) && !dis_i && !take_i;

  // Regulation rule: release the unwanted side after OFF, engage the wanted one after ON
  always_comb begin
    if (want_hs) begin
      ls_nx = ls_q && !off_due;
      hs_nx = hs_q || (on_due && !ls_q);
    end else begin
      hs_nx = hs_q && !off_due;
      ls_nx = ls_q || (on_due && !hs_q);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ph_q  <= PH_LOCK;
      hs_q  <= 1'b0;
      ls_q  <= 1'b0;
      dly_q <= '0;
      wd_q  <= '0;
      tmr_q <= '0;
    end else begin
      if (!hs_run || wd_fire) wd_q <= '0;
      else if (wd_q != WD_LAST) wd_q <= wd_q + 1'b1;

      if (lock_i) begin
        ph_q <= PH_LOCK;
        hs_q <= 1'b0;
        ls_q <= 1'b0;
      end else begin
        case (ph_q)
          PH_LOCK: begin
            ph_q  <= PH_PRE;
            hs_q  <= 1'b0;
            ls_q  <= 1'b1;
            tmr_q <= '0;
          end
          PH_PRE: begin
            if (tmr_q == PRE_LAST) begin
              ph_q  <= dis_i ? PH_DIS : PH_RUN;
              dly_q <= '0;
            end else begin
              tmr_q <= tmr_q + 1'b1;
            end
          end
          PH_DIS: begin
            hs_q <= 1'b0;
            ls_q <= 1'b1;
            if (!dis_i) begin
              ph_q  <= PH_RUN;
              dly_q <= '0;
            end
          end
          PH_REFRESH: begin
            if (dis_i) begin
              ph_q <= PH_DIS;
              hs_q <= 1'b0;
              ls_q <= 1'b1;
            end else if (take_i) begin
              ph_q  <= PH_RUN;
              dly_q <= '0;
            end else if (tmr_q == REF_LAST) begin
              ph_q  <= PH_RUN;
              ls_q  <= 1'b0;
              dly_q <= OFF_SET;
            end else begin
              tmr_q <= tmr_q + 1'b1;
            end
          end
          PH_RUN: begin
            if (dis_i) begin
              ph_q <= PH_DIS;
              hs_q <= 1'b0;
              ls_q <= 1'b1;
            end else if (take_i) begin
              dly_q <= '0;
            end else if (wd_fire) begin
              ph_q  <= PH_REFRESH;
              hs_q  <= 1'b0;
              ls_q  <= 1'b1;
              tmr_q <= '0;
            end else begin
              hs_q <= hs_nx;
              ls_q <= ls_nx;
              if (dly_q != ON_LAST) dly_q <= dly_q + 1'b1;
            end
          end
          default: ph_q <= PH_LOCK;
        endcase
      end
    end
  end

  assign hs_o = hs_q;
  assign ls_o = ls_q;

  // R1
  no_overlap_chk: assert property (@(posedge clk) disable iff (rst)
    !(hs_q && ls_q));

  // R1
  dead_gap_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(hs_q) |-> (!ls_q && !$past(ls_q)));

  // R8
  lock_low_chk: assert property (@(posedge clk) disable iff (rst)
    lock_i |=> (!hs_q && !ls_q));

  // R7
  dis_safe_chk: assert property (@(posedge clk) disable iff (rst)
    (!lock_i && dis_i) |=> (!hs_q && ls_q));

  // R10
  pre_entry_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(lock_i) |=> (ls_q && !hs_q));

endmodule

// File: rtl/hbk_gate_seq.sv
module hbk_gate_seq #(
  parameter int CLK_MHZ    = 100,
  parameter int FILT_NS    = 40,
  parameter int TURNOFF_NS = 180,
  parameter int TURNON_NS  = 320,
  parameter int WDOG_NS    = 20000,
  parameter int REFRESH_NS = 1000,
  parameter int PRECHG_NS  = 10000
) (
  input  logic clk,
  input  logic rst,
  input  logic fb_above_i,
  input  logic disable_i,
  input  logic vdd_above_on_i,
  input  logic vdd_below_off_i,
  output logic hs_gate_o,
  output logic ls_gate_o
);
  import hbk_pkg::*;

  // R11
  localparam int FILT_C = ns_to_cyc(CLK_MHZ, FILT_NS);
  localparam int OFF_C  = ns_to_cyc(CLK_MHZ, TURNOFF_NS);
  localparam int ON_C   = (ns_to_cyc(CLK_MHZ, TURNON_NS) > OFF_C) ?
                          ns_to_cyc(CLK_MHZ, TURNON_NS) : OFF_C + 1;
  localparam int WD_C   = ns_to_cyc(CLK_MHZ, WDOG_NS);
  localparam int REF_C  = ns_to_cyc(CLK_MHZ, REFRESH_NS);
  localparam int PRE_C  = ns_to_cyc(CLK_MHZ, PRECHG_NS);

  logic flt_lvl;
  logic flt_take;
  logic lock_q;

  hbk_deglitch #(.HOLD(FILT_C)) u_flt (
    .clk(clk), .rst(rst), .raw_i(fb_above_i),
    .lvl_o(flt_lvl), .take_o(flt_take)
  );

  hbk_uvlo u_uv (
    .clk(clk), .rst(rst), .above_on_i(vdd_above_on_i),
    .below_off_i(vdd_below_off_i), .lock_o(lock_q)
  );

  hbk_phase_ctl #(
    .OFF_C(OFF_C), .ON_C(ON_C), .WD_C(WD_C), .REF_C(REF_C), .PRE_C(PRE_C)
  ) u_ph (
    .clk(clk), .rst(rst), .lock_i(lock_q), .dis_i(disable_i),
    .lvl_i(flt_lvl), .take_i(flt_take),
    .hs_o(hs_gate_o), .ls_o(ls_gate_o)
  );

endmodule

// File: tb/sim_hbk_gate_seq.sv
`timescale 1ns/1ps
module sim_hbk_gate_seq;
  localparam int MHZ = 100;

  // R11: cycles = ns * MHz / 1000 (all defaults divide exactly)
  function automatic int cyc(input int ns);
    return ns * MHZ / 1000;
  endfunction

  localparam int F    = 40 * MHZ / 1000;
  localparam int OFF  = 180 * MHZ / 1000;
  localparam int ON   = 320 * MHZ / 1000;
  localparam int DEAD = ON - OFF;

  int WD, REF, PRE;
  int checks = 0;
  int errors = 0;
  bit done = 0;

  logic clk = 0;
  logic rst, fb, dis, above, below;
  logic hs, ls;

  always #5 clk = ~clk;

  hbk_gate_seq u0 (
    .clk(clk), .rst(rst), .fb_above_i(fb), .disable_i(dis),
    .vdd_above_on_i(above), .vdd_below_off_i(below),
    .hs_gate_o(hs), .ls_gate_o(ls)
  );

  task automatic step(input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      @(negedge clk);
    end
  endtask

  task automatic chk(input string tag, input logic eh, input logic el);
    checks++;
    if (hs !== eh || ls !== el) begin
      errors++;
      $display("FAIL %s: hs=%0b ls=%0b expected hs=%0b ls=%0b", tag, hs, ls, eh, el);
    end
  endtask

  // R1 monitor
  int overlap = 0;
  always @(negedge clk) begin
    if (!rst && hs === 1'b1 && ls === 1'b1) overlap++;
  end

  initial begin
    #2000000;
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: run did not complete, actual=hung expected=done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    WD  = cyc(20000);
    REF = cyc(1000);
    PRE = cyc(10000);
    rst = 1; fb = 0; dis = 0; above = 0; below = 1;
    repeat (3) @(negedge clk);
    rst = 0;
    chk("R8 reset locked", 0, 0);
    step(5);
    chk("R8 still locked", 0, 0);

    // leave lockout into precharge
    below = 0; above = 1;
    step(1);
    chk("R8 lock latency", 0, 0);
    step(1);
    chk("R10 precharge start", 0, 1);
    step(PRE + OFF - 1);
    chk("R10 precharge end hold", 0, 1);
    step(1);
    chk("R10 R3 ls release", 0, 0);
    step(DEAD - 1);
    chk("R10 R3 dead time", 0, 0);
    step(1);
    chk("R10 R3 hs on", 1, 0);

    // watchdog
    step(WD - 1);
    chk("R6 hs still on", 1, 0);
    step(1);
    chk("R6 refresh start", 0, 1);
    step(REF - 1);
    chk("R6 refresh hold", 0, 1);
    step(1);
    chk("R6 refresh end", 0, 0);
    step(DEAD - 1);
    chk("R6 gap", 0, 0);
    step(1);
    chk("R6 hs resumes", 1, 0);

    // rising feedback
    fb = 1;
    step(F + OFF - 1);
    chk("R2 R11 hs before off", 1, 0);
    step(1);
    chk("R2 R11 hs off", 0, 0);
    step(DEAD - 1);
    chk("R2 R11 dead", 0, 0);
    step(1);
    chk("R2 R11 ls on", 0, 1);

    // glitch one cycle shorter than filter
    fb = 0;
    step(F - 1);
    fb = 1;
    step(60);
    chk("R4 glitch ignored", 0, 1);

    // falling feedback
    fb = 0;
    step(F + OFF - 1);
    chk("R3 ls before off", 0, 1);
    step(1);
    chk("R3 ls off", 0, 0);
    step(DEAD - 1);
    chk("R3 dead", 0, 0);
    step(1);
    chk("R3 hs on", 1, 0);

    // reversal while ls turn-on pending
    fb = 1;
    step(F + OFF);
    chk("R5 hs off", 0, 0);
    step(3);
    fb = 0;
    step(F + ON - 1);
    chk("R5 ls never on", 0, 0);
    step(1);
    chk("R5 hs back on", 1, 0);

    // disable
    dis = 1;
    step(1);
    chk("R7 disable state", 0, 1);
    fb = 1;
    step(10);
    fb = 0;
    step(40);
    chk("R7 feedback ignored", 0, 1);
    dis = 0;
    step(OFF);
    chk("R7 release hold", 0, 1);
    step(1);
    chk("R7 release ls off", 0, 0);
    step(DEAD - 1);
    chk("R7 release dead", 0, 0);
    step(1);
    chk("R7 release hs on", 1, 0);

    // lockout hysteresis
    above = 0; below = 0;
    step(10);
    chk("R9 band no lock", 1, 0);
    below = 1;
    step(1);
    chk("R8 lock latency", 1, 0);
    step(1);
    chk("R8 locked low", 0, 0);
    below = 0;
    step(20);
    chk("R9 band stays locked", 0, 0);
    above = 1;
    step(2);
    chk("R10 precharge again", 0, 1);

    checks++;
    if (overlap != 0) begin
      errors++;
      $display("FAIL R1: overlap cycles=%0d expected=0", overlap);
    end

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule